// File: doc/BRIEF.md
# Status-coded I2C master engine

This block is a byte-level I2C bus master that software steps through one bus event at a time. Software changes control bits through a set port and a clear port rather than by read-modify-write. It asks for a start condition, loads an address or data byte into the data register, and chooses whether a received byte gets an ACK or a NACK. When each event is finished, the engine sets a serial-interrupt flag and presents an 8-bit status code that names the event. It then holds SCL low until software clears the flag. Clearing the flag is the only thing that lets the engine go on to its next action.

The SCL low time and high time are taken from two count inputs, each given in clock cycles. A 50% duty cycle at f_scl comes from loading both with f_clk/(2·f_scl). Both lines are open drain. The engine pulls a line low through a drive-low output and reads the resolved level on the matching input. While SCL is released, a slave holding it low stretches the high phase.

Top module: `i2c_status_master`

## Requirements
- R1: The control value has interface enable at bit 6, start request at bit 5, stop request at bit 4, serial-interrupt flag at bit 3 and assert-acknowledge at bit 2. All other bits read 0. A 1 written through the set port sets the matching bit, and a 1 written through the clear port clears it. A 1 written to bit 3 through the set port has no effect. While enable is 0, bits 5, 4 and 3 are held at 0. Clearing enable also releases both lines, and the status then reads 0xF8.
- R2: After reset, the control value is 0x00, the status reads 0xF8 and neither line is driven.
- R3: A start request with enable set and the flag clear produces a start condition: SDA falls while SCL is high. It waits until both lines are high. On completion the flag sets and the status reads 0x08.
- R4: A start request that is pending when the flag is cleared while the engine still owns the bus produces a repeated start, with status 0x10.
- R5: The first byte after a start is an address whose bit 0 selects read (1) or write (0). An ACKed write address gives 0x18 and a NACKed one gives 0x20. An ACKed read address gives 0x40 and a NACKed one gives 0x48.
- R6: Data bytes in write direction go out MSB first. An ACKed byte gives 0x28 and a NACKed byte gives 0x30.
- R7: In read direction each byte is shifted in MSB first and then appears in the data register. Assert-acknowledge set answers the byte with ACK and gives 0x50. Assert-acknowledge clear answers with NACK and gives 0x58.
- R8: While the flag is set and the engine owns the bus, SCL is held low and SDA does not change.
- R9: A stop request acted on in place of the next action produces a stop condition: SDA rises while SCL is high. The stop bit then clears itself, the flag stays clear and the status reads 0xF8.
- R10: Each SCL low phase of a byte lasts the low count in cycles, and each high phase lasts the high count.
- R11: If the engine releases SDA to send a 1 in an address or data bit and samples SDA low, it releases both lines, sets the flag and reports 0x38. Clearing the flag then gives 0xF8.
- R12: SDA changes while SCL is high only as part of a start or stop condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ctl_set_we | input | 1 | Write strobe: set the control bits that are 1 in ctl_wdata |
| ctl_clr_we | input | 1 | Write strobe: clear the control bits that are 1 in ctl_wdata |
| ctl_wdata | input | 8 | Bit mask for the set and clear writes |
| ctl_q | output | 8 | Current control value |
| stat_q | output | 8 | Status code, or 0xF8 while the flag is clear |
| dat_we | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Byte to transmit |
| dat_q | output | 8 | Data register (last byte received or written) |
| scl_low_cnt | input | CNT_W | SCL low-phase length in cycles |
| scl_high_cnt | input | CNT_W | SCL high-phase length in cycles |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |

## Verification
The bench runs against a modelled slave. It covers the start versus repeated-start codes, NACK on a read address, NACK on a data byte, and the final NACKed read. An engine that lost track of bus ownership would report 0x08 for the repeated start, and one that kept the wrong direction would report write codes after a read address. A second driver holds SDA low in two places: before a start, to check that the engine waits for a free bus, and during an address 1-bit, to check that loss is reported with both lines released and not as a NACK. Further checks cover SCL stuck low with SDA unchanged over a long hold, exact phase lengths, and dropping enable in mid-transfer, which must clear the pending requests rather than leave the bus half-driven.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CB_EN  = 6;
  localparam int CB_STA = 5;
  localparam int CB_STO = 4;
  localparam int CB_SI  = 3;
  localparam int CB_AA  = 2;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NAK  = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NAK  = 8'h30;
  localparam logic [7:0] ST_LOST    = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NAK  = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NAK  = 8'h58;
  localparam logic [7:0] ST_NONE    = 8'hF8;

  typedef enum logic [3:0] {
    PH_IDLE, PH_STA_SU, PH_STA_HD, PH_HOLD, PH_BIT_LO, PH_BIT_HI,
    PH_RS_LO, PH_STO_LO, PH_STO_HI, PH_STO_END
  } phase_t;
endpackage

// File: rtl/i2cm_ctl_reg.sv
module i2cm_ctl_reg
  import i2cm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  input  logic         hw_si_set,
  input  logic         hw_sto_clr,
  output logic [W-1:0] ctl_q
);
  localparam logic [W-1:0] IMPL   = W'((1 << CB_EN) | (1 << CB_STA) | (1 << CB_STO) |
                                       (1 << CB_SI) | (1 << CB_AA));
  localparam logic [W-1:0] SW_SET = IMPL & ~W'(1 << CB_SI);

  logic [W-1:0] nx;

  always_comb begin
    nx = ctl_q;
    if (set_we) nx = nx | (wdata & SW_SET);
    if (clr_we) nx = nx & ~wdata;
    if (hw_sto_clr) nx[CB_STO] = 1'b0;
    if (hw_si_set)  nx[CB_SI]  = 1'b1;
    if (!nx[CB_EN]) begin
      nx[CB_STA] = 1'b0;
      nx[CB_STO] = 1'b0;
      nx[CB_SI]  = 1'b0;
    end
    nx = nx & IMPL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= nx;
  end

  // R1
  si_hw_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_q[CB_SI]) |-> $past(hw_si_set));

  // R9
  sto_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctl_q[CB_STO]) |-> ($past(hw_sto_clr || (clr_we && wdata[CB_STO])) || !ctl_q[CB_EN]));
endmodule

// File: rtl/i2cm_phase_timer.sv
module i2cm_phase_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= (load_val == '0) ? '0 : load_val - CW'(1);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_set_we,
  input  logic             ctl_clr_we,
  input  logic [7:0]       ctl_wdata,
  output logic [7:0]       ctl_q,
  output logic [7:0]       stat_q,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  output logic [7:0]       dat_q,
  input  logic [CNT_W-1:0] scl_low_cnt,
  input  logic [CNT_W-1:0] scl_high_cnt,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drive_low,
  output logic             sda_drive_low
);
  localparam int BITS  = 8;
  localparam int BIT_W = $clog2(BITS + 1);
  localparam logic [BIT_W-1:0] ACK_BIT = BIT_W'(BITS);

  phase_t st, st_n;
  logic [BIT_W-1:0] bitn, bitn_n;
  logic [7:0] sh, sh_n, code, code_n;
  logic btx, btx_n, rxm, rxm_n, first, first_n, onbus, onbus_n, sda_drv, sda_n;
  logic si_set, sto_clr, dat_load, tdone, tload;
  logic [CNT_W-1:0] tval;
  logic en, sta, sto, si, aa;

  assign en  = ctl_q[CB_EN];
  assign sta = ctl_q[CB_STA];
  assign sto = ctl_q[CB_STO];
  assign si  = ctl_q[CB_SI];
  assign aa  = ctl_q[CB_AA];

  i2cm_ctl_reg #(.W(8)) u_ctl (
    .clk(clk), .rst_n(rst_n), .set_we(ctl_set_we), .clr_we(ctl_clr_we),
    .wdata(ctl_wdata), .hw_si_set(si_set), .hw_sto_clr(sto_clr), .ctl_q(ctl_q)
  );

  assign tload = (st_n != st);
  assign tval  = (st_n inside {PH_BIT_LO, PH_RS_LO, PH_STO_LO}) ? scl_low_cnt : scl_high_cnt;

  i2cm_phase_timer #(.CW(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tload), .load_val(tval), .done(tdone)
  );

  always_comb begin
    st_n = st; bitn_n = bitn; sh_n = sh; btx_n = btx; rxm_n = rxm;
    first_n = first; onbus_n = onbus; sda_n = sda_drv; code_n = code;
    si_set = 1'b0; sto_clr = 1'b0; dat_load = 1'b0;
    case (st)
      PH_IDLE: begin
        sda_n = 1'b0;
        if (sto) sto_clr = 1'b1;
        else if (sta && !si && scl_in && sda_in) st_n = PH_STA_SU;
      end
      PH_STA_SU: if (tdone) begin st_n = PH_STA_HD; sda_n = 1'b1; end
      PH_STA_HD: if (tdone) begin
        st_n = PH_HOLD; code_n = onbus ? ST_RSTART : ST_START;
        onbus_n = 1'b1; first_n = 1'b1; si_set = 1'b1;
      end
      PH_HOLD: if (!si) begin
        if (sto)      st_n = PH_STO_LO;
        else if (sta) st_n = PH_RS_LO;
        else begin
          st_n = PH_BIT_LO; bitn_n = '0;
          if (first || !rxm) begin
            btx_n = 1'b1; sh_n = dat_q;
            if (first) rxm_n = dat_q[0];
          end else btx_n = 1'b0;
        end
      end
      PH_BIT_LO: begin
        sda_n = (bitn == ACK_BIT) ? (!btx && aa) : (btx && !sh[7]);
        if (tdone) st_n = PH_BIT_HI;
      end
      PH_BIT_HI: if (tdone && scl_in) begin
        if (bitn != ACK_BIT) begin
          if (btx && !sda_drv && !sda_in) begin
            st_n = PH_IDLE; code_n = ST_LOST; si_set = 1'b1;
            onbus_n = 1'b0; sda_n = 1'b0;
          end else begin
            sh_n = {sh[6:0], sda_in}; bitn_n = bitn + BIT_W'(1); st_n = PH_BIT_LO;
          end
        end else begin
          st_n = PH_HOLD; si_set = 1'b1; first_n = 1'b0;
          if (btx) begin
            if (first) code_n = rxm ? (sda_in ? ST_AR_NAK : ST_AR_ACK)
                                    : (sda_in ? ST_AW_NAK : ST_AW_ACK);
            else       code_n = sda_in ? ST_DW_NAK : ST_DW_ACK;
          end else begin
            code_n = sda_in ? ST_DR_NAK : ST_DR_ACK;
            dat_load = 1'b1;
          end
        end
      end
      PH_RS_LO:  begin sda_n = 1'b0; if (tdone) st_n = PH_STA_SU; end
      PH_STO_LO: begin sda_n = 1'b1; if (tdone) st_n = PH_STO_HI; end
      PH_STO_HI: if (tdone && scl_in) begin st_n = PH_STO_END; sda_n = 1'b0; end
      PH_STO_END: if (tdone) begin st_n = PH_IDLE; sto_clr = 1'b1; onbus_n = 1'b0; end
      default: st_n = PH_IDLE;
    endcase
    if (!en) begin
      st_n = PH_IDLE; sda_n = 1'b0; onbus_n = 1'b0;
      si_set = 1'b0; sto_clr = 1'b0; dat_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PH_IDLE; bitn <= '0; sh <= '0; btx <= 1'b0; rxm <= 1'b0;
      first <= 1'b0; onbus <= 1'b0; sda_drv <= 1'b0; code <= ST_NONE; dat_q <= '0;
    end else begin
      st <= st_n; bitn <= bitn_n; sh <= sh_n; btx <= btx_n; rxm <= rxm_n;
      first <= first_n; onbus <= onbus_n; sda_drv <= sda_n; code <= code_n;
      if (dat_load)    dat_q <= sh;
      else if (dat_we) dat_q <= dat_wdata;
    end
  end

  assign scl_drive_low = st inside {PH_BIT_LO, PH_HOLD, PH_RS_LO, PH_STO_LO};
  assign sda_drive_low = sda_drv;
  assign stat_q        = si ? code : ST_NONE;

  // R8
  hold_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && onbus) |-> scl_drive_low);

  // R8
  hold_sda_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (si && onbus && $past(si && onbus)) |-> $stable(sda_drive_low));

  // R12
  sda_high_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_drive_low && !$past(scl_drive_low) && !$stable(sda_drive_low))
      |-> (st inside {PH_STA_HD, PH_STO_END, PH_IDLE}));
endmodule

// File: tb/sim_i2c_status_master.sv
`timescale 1ns/1ps
module sim_i2c_status_master;
  localparam int LO = 6;
  localparam int HI = 5;
  localparam int NV = 19;
  localparam logic [6:0] SADDR = 7'h5A;

  // vector: [19:18] op (0 start,1 send,2 receive,3 stop) [17:10] byte [9] aa [8] check data [7:0] status
  localparam logic [19:0] VEC [NV] = '{
    {2'd0, 8'h00, 1'b0, 1'b0, 8'h08},
    {2'd1, 8'hB4, 1'b0, 1'b0, 8'h18},
    {2'd1, 8'h3C, 1'b0, 1'b0, 8'h28},
    {2'd1, 8'h81, 1'b0, 1'b0, 8'h28},
    {2'd0, 8'h00, 1'b0, 1'b0, 8'h10},
    {2'd1, 8'hB5, 1'b0, 1'b0, 8'h40},
    {2'd2, 8'hA5, 1'b1, 1'b1, 8'h50},
    {2'd2, 8'hB6, 1'b0, 1'b1, 8'h58},
    {2'd3, 8'h00, 1'b0, 1'b0, 8'hF8},
    {2'd0, 8'h00, 1'b0, 1'b0, 8'h08},
    {2'd1, 8'hA0, 1'b0, 1'b0, 8'h20},
    {2'd3, 8'h00, 1'b0, 1'b0, 8'hF8},
    {2'd0, 8'h00, 1'b0, 1'b0, 8'h08},
    {2'd1, 8'hA1, 1'b0, 1'b0, 8'h48},
    {2'd3, 8'h00, 1'b0, 1'b0, 8'hF8},
    {2'd0, 8'h00, 1'b0, 1'b0, 8'h08},
    {2'd1, 8'hB4, 1'b0, 1'b0, 8'h18},
    {2'd1, 8'hFF, 1'b0, 1'b0, 8'h30},
    {2'd3, 8'h00, 1'b0, 1'b0, 8'hF8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctl_set_we = 1'b0, ctl_clr_we = 1'b0, dat_we = 1'b0;
  logic [7:0] ctl_wdata = '0, dat_wdata = '0;
  logic [7:0] ctl_q, stat_q, dat_q;
  logic scl_o, sda_o;
  logic s_pull = 1'b0, rogue = 1'b0;
  int nchk = 0, nfail = 0;

  wire scl_bus = !scl_o;
  wire sda_bus = !sda_o && !s_pull && !rogue;

  always #2 clk = ~clk;

  i2c_status_master #(.CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_set_we(ctl_set_we), .ctl_clr_we(ctl_clr_we),
    .ctl_wdata(ctl_wdata), .ctl_q(ctl_q), .stat_q(stat_q), .dat_we(dat_we),
    .dat_wdata(dat_wdata), .dat_q(dat_q), .scl_low_cnt(16'(LO)), .scl_high_cnt(16'(HI)),
    .scl_in(scl_bus), .sda_in(sda_bus), .scl_drive_low(scl_o), .sda_drive_low(sda_o)
  );

  // slave model at address SADDR
  logic p_scl = 1'b1, p_sda = 1'b1, s_act = 1'b0, s_first = 1'b0, s_read = 1'b0;
  logic s_sel = 1'b0, m_acked = 1'b0;
  logic [7:0] s_byte = '0, s_tx = '0;
  logic [7:0] wlog [8];
  int s_cnt = 0, s_rdix = 0, wn = 0;

  always @(scl_bus or sda_bus) begin
    if (scl_bus && p_scl && (sda_bus != p_sda)) begin
      if (!sda_bus) begin s_act = 1'b1; s_cnt = 0; s_first = 1'b1; s_sel = 1'b0; end
      else s_act = 1'b0;
      s_pull = 1'b0;
    end else if (scl_bus && !p_scl && s_act) begin
      s_byte = {s_byte[6:0], sda_bus};
      if (s_cnt == 8 && s_read && !s_first) m_acked = !sda_bus;
      s_cnt++;
    end else if (!scl_bus && p_scl && s_act) begin
      if (s_cnt == 8) begin
        if (s_first) begin
          s_sel = (s_byte[7:1] == SADDR); s_read = s_byte[0]; s_pull = s_sel; s_rdix = 0;
        end else if (s_sel && !s_read) begin
          if (wn < 8) wlog[wn] = s_byte;
          wn++;
          s_pull = (s_byte != 8'hFF);
        end else s_pull = 1'b0;
      end else if (s_cnt == 9) begin
        s_cnt = 0; s_pull = 1'b0;
        if (s_sel && s_read && (s_first || m_acked)) begin
          s_tx = 8'hA5 + 8'(s_rdix * 17); s_rdix++; s_pull = !s_tx[7];
        end else if (s_read) s_sel = 1'b0;
        s_first = 1'b0;
      end else if (s_cnt >= 1 && s_cnt <= 7 && s_sel && s_read && !s_first)
        s_pull = !s_tx[7 - s_cnt];
    end
    p_scl = scl_bus; p_sda = sda_bus;
  end

  // phase-length and SDA-while-high monitors
  int hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0, sda_viol = 0;
  logic q_scl = 1'b1, q_sda = 1'b1, watch = 1'b0;
  always @(negedge clk) begin
    if (scl_bus && !q_scl) begin last_lo = lo_run; hi_run = 0; end
    if (!scl_bus && q_scl) begin last_hi = hi_run; lo_run = 0; end
    if (scl_bus) hi_run++; else lo_run++;
    if (watch && scl_bus && q_scl && (sda_bus != q_sda)) sda_viol++;
    q_scl = scl_bus; q_sda = sda_bus;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic ctl_set(input logic [7:0] m);
    ctl_set_we = 1'b1; ctl_wdata = m; @(negedge clk); ctl_set_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic ctl_clr(input logic [7:0] m);
    ctl_clr_we = 1'b1; ctl_wdata = m; @(negedge clk); ctl_clr_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic dat_wr(input logic [7:0] b);
    dat_we = 1'b1; dat_wdata = b; @(negedge clk); dat_we = 1'b0;
  endtask

  task automatic wait_si(input string tag);
    int n = 0;
    while (!ctl_q[3] && n < 20000) begin @(negedge clk); n++; end
    if (!ctl_q[3]) chk({tag, " flag timeout"}, 0, 1);
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 ctl", ctl_q, 8'h00);
    chk("R2 stat", stat_q, 8'hF8);
    chk("R2 lines", {scl_o, sda_o}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 set/clear semantics
    ctl_set(8'h08); @(negedge clk);
    chk("R1 flag set ignored", ctl_q, 8'h00);
    ctl_set(8'h44); @(negedge clk);
    chk("R1 set en+aa", ctl_q, 8'h44);
    ctl_clr(8'h04); @(negedge clk);
    chk("R1 clear aa", ctl_q, 8'h40);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      logic [7:0] b, ex;
      op = VEC[i][19:18]; b = VEC[i][17:10]; ex = VEC[i][7:0];
      case (op)
        2'd0: begin
          ctl_set(8'h20);
          if (ctl_q[3]) ctl_clr(8'h08);
          wait_si("R3");
          ctl_clr(8'h20);
          chk((ex == 8'h10) ? "R4 repeated start" : "R3 start", stat_q, ex);
        end
        2'd1: begin
          dat_wr(b);
          if (i == 2) watch = 1'b1;
          ctl_clr(8'h08);
          wait_si("R5");
          watch = 1'b0;
          chk((i == 1 || i == 5 || i == 10 || i == 13 || i == 16) ? "R5 address" : "R6 data",
              stat_q, ex);
          if (i == 2) begin
            chk("R10 high phase", last_hi, HI);
            chk("R10 low phase", last_lo, LO);
            chk("R12 sda while scl high", sda_viol, 0);
          end
        end
        2'd2: begin
          if (VEC[i][9]) ctl_set(8'h04); else ctl_clr(8'h04);
          ctl_clr(8'h08);
          wait_si("R7");
          chk("R7 status", stat_q, ex);
          if (VEC[i][8]) chk("R7 data", dat_q, b);
        end
        default: begin
          int n = 0;
          ctl_set(8'h10);
          if (ctl_q[3]) ctl_clr(8'h08);
          while (ctl_q[4] && n < 20000) begin @(negedge clk); n++; end
          chk("R9 stop bit cleared", ctl_q[4], 1'b0);
          chk("R9 status", stat_q, ex);
          chk("R9 flag", ctl_q[3], 1'b0);
        end
      endcase
    end

    // R6 bytes seen by the slave, MSB first
    chk("R6 byte count", wn, 3);
    chk("R6 byte0", wlog[0], 8'h3C);
    chk("R6 byte1", wlog[1], 8'h81);
    chk("R6 byte2", wlog[2], 8'hFF);

    // R3 busy bus delays the start
    rogue = 1'b1;
    repeat (4) @(negedge clk);
    ctl_set(8'h20);
    repeat (100) @(negedge clk);
    chk("R3 wait for free bus", {ctl_q[3], scl_o}, 2'b00);
    rogue = 1'b0;
    wait_si("R3");
    ctl_clr(8'h20);
    chk("R3 start after free", stat_q, 8'h08);

    // R8 hold: SCL low, SDA unchanged
    begin
      logic sd0;
      sd0 = sda_o;
      repeat (200) @(negedge clk);
      chk("R8 scl held", scl_o, 1'b1);
      chk("R8 sda unchanged", sda_o, sd0);
      chk("R8 status kept", stat_q, 8'h08);
    end

    // R11 arbitration loss on the first address 1-bit
    rogue = 1'b1;
    dat_wr(8'hB4);
    ctl_clr(8'h08);
    wait_si("R11");
    chk("R11 status", stat_q, 8'h38);
    chk("R11 lines released", {scl_o, sda_o}, 2'b00);
    rogue = 1'b0;
    ctl_clr(8'h08); @(negedge clk);
    chk("R11 after clear", stat_q, 8'hF8);

    // R1 dropping enable mid-transfer
    ctl_set(8'h20);
    wait_si("R1");
    ctl_clr(8'h40);
    repeat (2) @(negedge clk);
    chk("R1 enable clear", ctl_q, 8'h00);
    chk("R1 enable lines", {scl_o, sda_o}, 2'b00);
    chk("R1 enable status", stat_q, 8'hF8);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule